// File: doc/BRIEF.md
# Delegated Interrupt Priority Selector

This block is a purely combinational selector that sits beside a hart's trap logic. Each cycle it looks at the pending, enable and delegation masks, the current privilege level and the two global interrupt-enable bits. It then reports whether an interrupt should be taken now, which one, and at which privilege level the handler must run. The trap-entry sequencer consumes these outputs directly. There is no handshake, because the selector holds no state and its outputs simply follow its inputs within the same cycle.

Candidates are the pending sources that are also enabled. The candidates are divided into two groups:

- Sources kept at Machine level.
- Sources handed down to Supervisor level by the delegation mask.

Each group has its own implicit enable, which depends on the running privilege. The Machine group is always examined first. Within either group a fixed ranking decides the winner: external, then software, then timer, and higher privilege before lower. Interrupts handed down to Supervisor stay masked while the hart runs in Machine mode.

Source positions in all three masks are:

| Source | Bit |
|---|---|
| Machine external | 11 |
| Supervisor external | 9 |
| User external | 8 |
| Machine timer | 7 |
| Supervisor timer | 5 |
| User timer | 4 |
| Machine software | 3 |
| Supervisor software | 1 |
| User software | 0 |

A source's bit position is also its cause code.

Top module: `irq_route_sel`

## Requirements
- R1: An interrupt is taken only if some source bit is set in both `pend_i` and `enab_i`. When no such bit exists, `hit_o` is 0.
- R2: Whenever `hit_o` is 0, both `code_o` and `tgt_lvl_o` are driven to 0.
- R3: `lvl_i` is encoded as follows: 2'b00 is User, 2'b01 is Supervisor and 2'b11 is Machine. The reserved value 2'b10 behaves exactly like Machine.
- R4: The Machine group may fire in the following cases. It fires whenever the level is User or Supervisor. At Machine level it fires only when `m_gie_i` is 1.
- R5: The Supervisor group may fire in the following cases. It fires always at User level, and at Supervisor level only when `s_gie_i` is 1. It never fires at Machine level.
- R6: `dlg_i` bits 11, 7 and 3 are treated as 0. Machine sources therefore always stay in the Machine group. Every other candidate with its `dlg_i` bit set goes to the Supervisor group, and the rest stay in the Machine group.
- R7: If the Machine group is non-empty and allowed to fire, it wins over any Supervisor-group candidate. In that case `tgt_lvl_o` is 2'b11.
- R8: Otherwise, if the Supervisor group is non-empty and allowed to fire, that group supplies the result. In that case `tgt_lvl_o` is 2'b01.
- R9: Within the chosen group the winner is the highest-ranked set bit. The ranking, highest first, is bit 11, 3, 7, 9, 1, 5, 8, 0, 4.
- R10: `code_o` equals the bit index of the chosen source. Bits 2, 6 and 10 are not sources: they never produce an interrupt, whatever their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_i | input | 12 | Pending source mask |
| enab_i | input | 12 | Enabled source mask |
| dlg_i | input | 12 | Delegation mask; a set bit hands the source down to Supervisor |
| lvl_i | input | 2 | Current privilege level |
| m_gie_i | input | 1 | Global Machine interrupt enable |
| s_gie_i | input | 1 | Global Supervisor interrupt enable |
| hit_o | output | 1 | An interrupt must be taken |
| code_o | output | 4 | Cause code (bit index) of the chosen source |
| tgt_lvl_o | output | 2 | Level that handles it: 2'b11 Machine, 2'b01 Supervisor, 2'b00 when idle |

## Verification
Single-source walks cover every mask bit, including the three non-source bits, and confirm that each code comes out unchanged. Source pairs taken from every pair of ranks in the priority list show that the ranking is applied and not just any set bit.

Group tests use the same pending pattern and vary only the following:
- The level.
- The two global enables.
- The delegation mask.

These tests separate the Machine gate from the Supervisor gate, show the retained group beating a higher-ranked delegated source, and expose any Machine bit wrongly handed down. The reserved level code is also applied, to tell a decoder that treats it as Machine apart from one that treats it as a lower level.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int unsigned SRC_W  = 12;
  localparam int unsigned RANK_N = 9;
  localparam int unsigned CODE_W = $clog2(SRC_W);

  typedef enum logic [1:0] {
    LVL_USR = 2'b00,
    LVL_SUP = 2'b01,
    LVL_RSV = 2'b10,
    LVL_MCH = 2'b11
  } lvl_e;

  // Source bit index at a given rank, rank 0 wins.
  function automatic logic [CODE_W-1:0] rank_src(input int unsigned r);
    case (r)
      0:       return CODE_W'(11);
      1:       return CODE_W'(3);
      2:       return CODE_W'(7);
      3:       return CODE_W'(9);
      4:       return CODE_W'(1);
      5:       return CODE_W'(5);
      6:       return CODE_W'(8);
      7:       return CODE_W'(0);
      default: return CODE_W'(4);
    endcase
  endfunction

  // All positions that carry a real source.
  function automatic logic [SRC_W-1:0] src_mask();
    logic [SRC_W-1:0] m;
    m = '0;
    for (int unsigned r = 0; r < RANK_N; r++) m[rank_src(r)] = 1'b1;
    return m;
  endfunction

  // Machine-level sources: never handed down.
  function automatic logic [SRC_W-1:0] mch_mask();
    logic [SRC_W-1:0] m;
    m = '0;
    m[11] = 1'b1;
    m[7]  = 1'b1;
    m[3]  = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_lvl_gate.sv
module irq_lvl_gate
  import irq_route_pkg::*;
(
  input  lvl_e lvl_i,
  input  logic m_gie_i,
  input  logic s_gie_i,
  output logic m_open_o,
  output logic s_open_o
);

  always_comb begin
    m_open_o = 1'b0;
    s_open_o = 1'b0;
    unique case (lvl_i)
      LVL_USR: begin
        m_open_o = 1'b1;
        s_open_o = 1'b1;
      end
      LVL_SUP: begin
        m_open_o = 1'b1;
        s_open_o = s_gie_i;
      end
      default: begin // Machine and the reserved code
        m_open_o = m_gie_i;
        s_open_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/irq_split.sv
module irq_split
  import irq_route_pkg::*;
#(
  parameter int unsigned W = SRC_W
) (
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] enab_i,
  input  logic [W-1:0] dlg_i,
  output logic [W-1:0] keep_o,
  output logic [W-1:0] pass_o
);

  localparam logic [W-1:0] LIVE = W'(src_mask());
  localparam logic [W-1:0] MCH  = W'(mch_mask());

  logic [W-1:0] cand;
  logic [W-1:0] dlg_eff;

  assign cand    = pend_i & enab_i & LIVE;
  assign dlg_eff = dlg_i & ~MCH;
  assign keep_o  = cand & ~dlg_eff;
  assign pass_o  = cand &  dlg_eff;

endmodule

// File: rtl/irq_rank_pick.sv
module irq_rank_pick
  import irq_route_pkg::*;
#(
  parameter int unsigned W  = SRC_W,
  parameter int unsigned N  = RANK_N,
  parameter int unsigned CW = CODE_W
) (
  input  logic [W-1:0]  set_i,
  output logic          found_o,
  output logic [CW-1:0] code_o
);

  logic [N:0]    above;
  logic [N-1:0]  win;
  logic [CW-1:0] code_acc [N+1];
  logic          unused_bits;

  assign above[0]    = 1'b0;
  assign code_acc[0] = '0;
  assign unused_bits = ^(set_i & ~W'(src_mask()));

  for (genvar r = 0; r < N; r++) begin : g_rank
    localparam logic [CW-1:0] IDX = CW'(rank_src(r));
    logic req;
    assign req             = set_i[IDX];
    assign win[r]          = req & ~above[r];
    assign above[r+1]      = above[r] | req;
    assign code_acc[r+1]   = code_acc[r] | ({CW{win[r]}} & IDX);
  end

  assign found_o = above[N];
  assign code_o  = code_acc[N];

endmodule

// File: rtl/irq_route_sel.sv
module irq_route_sel
  import irq_route_pkg::*;
#(
  parameter int unsigned W  = SRC_W,
  parameter int unsigned CW = CODE_W
) (
  input  logic [W-1:0]  pend_i,
  input  logic [W-1:0]  enab_i,
  input  logic [W-1:0]  dlg_i,
  input  logic [1:0]    lvl_i,
  input  logic          m_gie_i,
  input  logic          s_gie_i,
  output logic          hit_o,
  output logic [CW-1:0] code_o,
  output logic [1:0]    tgt_lvl_o
);

  logic [W-1:0]  keep_set, pass_set;
  logic          m_open, s_open;
  logic          m_found, s_found;
  logic [CW-1:0] m_code, s_code;
  logic          m_take, s_take;

  irq_split #(.W(W)) split_i (
    .pend_i (pend_i),
    .enab_i (enab_i),
    .dlg_i  (dlg_i),
    .keep_o (keep_set),
    .pass_o (pass_set)
  );

  irq_lvl_gate gate_i (
    .lvl_i    (lvl_e'(lvl_i)),
    .m_gie_i  (m_gie_i),
    .s_gie_i  (s_gie_i),
    .m_open_o (m_open),
    .s_open_o (s_open)
  );

  irq_rank_pick #(.W(W), .N(RANK_N), .CW(CW)) pick_m_i (
    .set_i   (keep_set),
    .found_o (m_found),
    .code_o  (m_code)
  );

  irq_rank_pick #(.W(W), .N(RANK_N), .CW(CW)) pick_s_i (
    .set_i   (pass_set),
    .found_o (s_found),
    .code_o  (s_code)
  );

  assign m_take = m_open & m_found;
  assign s_take = ~m_take & s_open & s_found;

  always_comb begin
    hit_o     = m_take | s_take;
    code_o    = '0;
    tgt_lvl_o = LVL_USR;
    if (m_take) begin
      code_o    = m_code;
      tgt_lvl_o = LVL_MCH;
    end else if (s_take) begin
      code_o    = s_code;
      tgt_lvl_o = LVL_SUP;
    end
  end

endmodule

// File: rtl/irq_route_sel_chk.sv
module irq_route_sel_chk #(
  parameter int unsigned W  = 12,
  parameter int unsigned CW = 4
) (
  input logic [W-1:0]  pend_i,
  input logic [W-1:0]  enab_i,
  input logic [W-1:0]  dlg_i,
  input logic [1:0]    lvl_i,
  input logic          m_gie_i,
  input logic          s_gie_i,
  input logic          hit_o,
  input logic [CW-1:0] code_o,
  input logic [1:0]    tgt_lvl_o
);

  logic code_in;
  logic code_mch;
  assign code_in  = (32'(code_o) < W);
  assign code_mch = (code_o == CW'(11)) || (code_o == CW'(7)) || (code_o == CW'(3));

  always_comb begin
    AST_NO_CAND_IDLE: assert (((pend_i & enab_i) != '0) || !hit_o)
      else $error("hit without candidate"); // R1
    AST_IDLE_ZERO: assert (hit_o || (code_o == '0 && tgt_lvl_o == 2'b00))
      else $error("idle outputs not zero"); // R2
    AST_CODE_LIVE: assert (!hit_o || (code_in && pend_i[code_o] && enab_i[code_o]))
      else $error("chosen source not a candidate"); // R10
    AST_TGT_LEGAL: assert (!hit_o || tgt_lvl_o == 2'b11 || tgt_lvl_o == 2'b01)
      else $error("bad target level"); // R7
    AST_MCH_GATE: assert (!(hit_o && tgt_lvl_o == 2'b11 && lvl_i[1]) || m_gie_i)
      else $error("machine group fired while gated"); // R4
    AST_SUP_GATE: assert (!(hit_o && tgt_lvl_o == 2'b01) ||
                          (lvl_i == 2'b00 || (lvl_i == 2'b01 && s_gie_i)))
      else $error("supervisor group fired while gated"); // R5
    AST_SUP_DLG: assert (!(hit_o && tgt_lvl_o == 2'b01) ||
                         (code_in && dlg_i[code_o] && !code_mch))
      else $error("supervisor target for a kept source"); // R6
    AST_MCH_KEPT: assert (!(hit_o && tgt_lvl_o == 2'b11) ||
                          (code_in && (!dlg_i[code_o] || code_mch)))
      else $error("machine target for a delegated source"); // R8
  end

endmodule

bind irq_route_sel irq_route_sel_chk #(.W(W), .CW(CW)) chk_i (
  .pend_i    (pend_i),
  .enab_i    (enab_i),
  .dlg_i     (dlg_i),
  .lvl_i     (lvl_i),
  .m_gie_i   (m_gie_i),
  .s_gie_i   (s_gie_i),
  .hit_o     (hit_o),
  .code_o    (code_o),
  .tgt_lvl_o (tgt_lvl_o)
);

// File: tb/irq_route_sel_tb.sv
module irq_route_sel_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [11:0] pend, enab, dlg;
  logic [1:0]  lvl;
  logic        mgie, sgie;
  logic        hit;
  logic [3:0]  code;
  logic [1:0]  tgt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  irq_route_sel dut_i (
    .pend_i    (pend),
    .enab_i    (enab),
    .dlg_i     (dlg),
    .lvl_i     (lvl),
    .m_gie_i   (mgie),
    .s_gie_i   (sgie),
    .hit_o     (hit),
    .code_o    (code),
    .tgt_lvl_o (tgt)
  );

  typedef struct packed {
    logic [11:0] p;
    logic [11:0] e;
    logic [11:0] d;
    logic [1:0]  l;
    logic        mg;
    logic        sg;
    logic        h;
    logic [3:0]  c;
    logic [1:0]  t;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VT [NV] = '{
    '{12'h000, 12'hFFF, 12'h000, 2'd3, 1'b1, 1'b1, 1'b0, 4'd0,  2'd0, 4'd1},  // R1 nothing pending
    '{12'h080, 12'h000, 12'h000, 2'd3, 1'b1, 1'b1, 1'b0, 4'd0,  2'd0, 4'd1},  // R1 pending but disabled
    '{12'h888, 12'hFFF, 12'h000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd11, 2'd3, 4'd9},  // R9 external first
    '{12'h088, 12'hFFF, 12'h000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd3,  2'd3, 4'd9},  // R9 software over timer
    '{12'h080, 12'hFFF, 12'h000, 2'd3, 1'b0, 1'b1, 1'b0, 4'd0,  2'd0, 4'd4},  // R4 machine gated
    '{12'h080, 12'hFFF, 12'h000, 2'd1, 1'b0, 1'b0, 1'b1, 4'd7,  2'd3, 4'd4},  // R4 open below machine
    '{12'h080, 12'hFFF, 12'h000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd7,  2'd3, 4'd4},  // R4 open at user
    '{12'h222, 12'hFFF, 12'h222, 2'd1, 1'b0, 1'b1, 1'b1, 4'd9,  2'd1, 4'd8},  // R8 delegated taken
    '{12'h222, 12'hFFF, 12'h222, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0,  2'd0, 4'd5},  // R5 sup gated
    '{12'h222, 12'hFFF, 12'h222, 2'd0, 1'b0, 1'b0, 1'b1, 4'd9,  2'd1, 4'd5},  // R5 open at user
    '{12'h222, 12'hFFF, 12'h222, 2'd3, 1'b1, 1'b1, 1'b0, 4'd0,  2'd0, 4'd5},  // R5 closed at machine
    '{12'h222, 12'hFFF, 12'h200, 2'd1, 1'b0, 1'b1, 1'b1, 4'd1,  2'd3, 4'd7},  // R7 kept beats delegated
    '{12'h800, 12'hFFF, 12'h800, 2'd3, 1'b1, 1'b0, 1'b1, 4'd11, 2'd3, 4'd6},  // R6 machine bit not handed down
    '{12'h800, 12'hFFF, 12'h888, 2'd1, 1'b0, 1'b1, 1'b1, 4'd11, 2'd3, 4'd6},  // R6
    '{12'h400, 12'hFFF, 12'h000, 2'd0, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd10}, // R10 bit 10 dead
    '{12'h111, 12'hFFF, 12'h111, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8,  2'd1, 4'd9},  // R9 user group
    '{12'h011, 12'hFFF, 12'h011, 2'd0, 1'b0, 1'b0, 1'b1, 4'd0,  2'd1, 4'd10}, // R10 code zero valid
    '{12'h010, 12'hFFF, 12'h010, 2'd0, 1'b0, 1'b0, 1'b1, 4'd4,  2'd1, 4'd9},  // R9 lowest rank
    '{12'h280, 12'hFFF, 12'h000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd7,  2'd3, 4'd9},  // R9 M timer over S ext
    '{12'h222, 12'hFFF, 12'h222, 2'd2, 1'b1, 1'b1, 1'b0, 4'd0,  2'd0, 4'd3},  // R3 reserved as machine
    '{12'h080, 12'hFFF, 12'h000, 2'd2, 1'b0, 1'b0, 1'b0, 4'd0,  2'd0, 4'd3},  // R3
    '{12'hFFF, 12'h002, 12'h000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd1,  2'd3, 4'd1},  // R1 enable filters
    '{12'h0A2, 12'hFFF, 12'h022, 2'd1, 1'b1, 1'b1, 1'b1, 4'd7,  2'd3, 4'd7},  // R7
    '{12'h280, 12'hFFF, 12'h200, 2'd1, 1'b0, 1'b1, 1'b1, 4'd7,  2'd3, 4'd7},  // R7 rank ignored across groups
    '{12'h280, 12'hFFF, 12'h200, 2'd3, 1'b0, 1'b1, 1'b0, 4'd0,  2'd0, 4'd4}   // R4
  };

  localparam int PRI [9] = '{11, 3, 7, 9, 1, 5, 8, 0, 4}; // R9 ranking

  task automatic drive(input logic [11:0] p, input logic [11:0] e, input logic [11:0] d,
                       input logic [1:0] l, input logic mg, input logic sg);
    @(posedge clk);
    #1;
    pend = p; enab = e; dlg = d; lvl = l; mgie = mg; sgie = sg;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic eh, input logic [3:0] ec, input logic [1:0] et);
    total++;
    if (hit !== eh || code !== ec || tgt !== et) begin
      bad++;
      $display("FAIL %s: got hit=%0b code=%0d tgt=%0d expected hit=%0b code=%0d tgt=%0d",
               tag, hit, code, tgt, eh, ec, et);
    end
  endtask

  function automatic bit is_src(input int b);
    for (int k = 0; k < 9; k++) if (PRI[k] == b) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    pend = '0; enab = '0; dlg = '0; lvl = 2'd3; mgie = 1'b0; sgie = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 reset state", 1'b0, 4'd0, 2'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i].p, VT[i].e, VT[i].d, VT[i].l, VT[i].mg, VT[i].sg);
      chk($sformatf("R%0d vec %0d", VT[i].rq, i), VT[i].h, VT[i].c, VT[i].t);
    end

    // R10 walking single source, all kept at machine
    for (int b = 0; b < 12; b++) begin
      drive(12'(1 << b), 12'hFFF, 12'h000, 2'd3, 1'b1, 1'b0);
      if (is_src(b)) chk($sformatf("R10 walk bit %0d", b), 1'b1, 4'(b), 2'd3);
      else           chk($sformatf("R10 walk bit %0d", b), 1'b0, 4'd0, 2'd0);
    end

    // R9 every pair of ranks
    for (int i = 0; i < 9; i++) begin
      for (int j = i + 1; j < 9; j++) begin
        drive(12'((1 << PRI[i]) | (1 << PRI[j])), 12'hFFF, 12'h000, 2'd3, 1'b1, 1'b0);
        chk($sformatf("R9 pair %0d/%0d", PRI[i], PRI[j]), 1'b1, 4'(PRI[i]), 2'd3);
      end
    end

    // R2 everything pending but machine gated in machine mode
    drive(12'hFFF, 12'hFFF, 12'h000, 2'd3, 1'b0, 1'b1);
    chk("R2 gated idle", 1'b0, 4'd0, 2'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: got hung expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule